// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the control strobes of an asynchronous DRAM: row strobe, upper and lower column strobes, write enable and output enable. It samples them with a fast system clock and, for every period in which the row strobe is low, decides what kind of access the controller performed. The decision rests on the order in which strobe edges arrive, not on levels captured at one instant. The column-strobe mode follows the OR of the two column strobes, while write lanes are tracked per byte.

Each row-strobe period closes with a one-cycle result pulse. The pulse carries a 3-bit cycle code, a 2-bit mask of the byte lanes that were written, and a flag for column strobes that fell at different samples. The block sits next to a memory controller as a protocol checker. All strobe inputs are active low and asynchronous, and they pass through a synchronizer before any edge is judged. Edges that land in the same sample count as simultaneous.

Top module: `strobe_cycle_classifier`

## Requirements
- R1: If either column strobe is low in the first sample where the row strobe is seen low, the period closes with code 6 (refresh with column strobe first), lane mask 0 and stagger flag 0, whatever write enable does.
- R2: A row-strobe period in which no column strobe goes low closes with code 5 (row-only refresh), lane mask 0.
- R3: If write enable is low in the sample where the first column strobe of a column period is first seen low, the period closes with code 2 (early write).
- R4: If write enable falls while a column strobe is low, after that column period began, and output enable was not low earlier in that column period, the code is 3 (delayed write).
- R5: If write enable falls as in R4 but output enable was seen low earlier in the same column period, the code is 4 (read-modify-write).
- R6: A period with column activity and no write closes with code 1 (read) and lane mask 0.
- R7: Lane mask bit 0 (lower byte) is set if the lower column strobe and write enable were low in the same sample during the period. Bit 1 (upper byte) works the same way with the upper column strobe.
- R8: The stagger flag is set when a column strobe falls later than the sample that began the current column period, while the other strobe is still low. It stays 0 when both fall in the same sample or when only one strobe is used.
- R9: One row period may hold several column periods (page mode). The code then covers all of them with priority early write > read-modify-write > delayed write > read, and a single-strobe access is classified like a two-strobe one.
- R10: The result pulse lasts exactly one cycle. It appears within four clock cycles after the row strobe rises at the input. While no pulse is present, code (0, standby), lane mask and stagger flag are all 0, and this is also the state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low, asynchronous |
| ucas_n_i | input | 1 | Upper-byte column strobe, active low |
| lcas_n_i | input | 1 | Lower-byte column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| cyc_valid_o | output | 1 | One-cycle pulse when a row period closes |
| cyc_kind_o | output | 3 | Cycle code (0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-first refresh) |
| wr_lanes_o | output | 2 | Written byte lanes, bit 0 lower, bit 1 upper |
| stagger_o | output | 1 | Column strobes fell in different samples |

## Verification
The bench targets the edge-order corners. In a column-first refresh with write enable also low, a design that checks levels rather than order would report a write with lanes set. A single-strobe delayed write must set only its own lane bit, and a design that ORs the lanes would show both. Output enable going low and then high before write enable falls separates read-modify-write from delayed write, and getting this wrong swaps codes 3 and 4. A two-page period that reads first and then writes early checks the priority rule, and a lagging second column strobe checks the stagger flag, which a broken design either misses or raises on simultaneous falls.

// File: rtl/strobe_cycle_classifier.sv
module strobe_cycle_classifier #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n_i,
  input  logic       ucas_n_i,
  input  logic       lcas_n_i,
  input  logic       we_n_i,
  input  logic       oe_n_i,
  output logic       cyc_valid_o,
  output logic [2:0] cyc_kind_o,
  output logic [1:0] wr_lanes_o,
  output logic       stagger_o
);
  typedef enum logic [2:0] {
    K_IDLE = 3'd0, K_READ = 3'd1, K_EARLY = 3'd2, K_LATE = 3'd3,
    K_RMW = 3'd4, K_RONLY = 3'd5, K_CBR = 3'd6
  } kind_e;

  localparam int LINES = 5;

  // line order: 0 row, 1 lower col, 2 upper col, 3 write, 4 output enable
  logic [LINES-1:0] pipe [SYNC_STAGES];
  logic [LINES-1:0] cur, prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '1;
      prv <= '1;
    end else begin
      pipe[0] <= {oe_n_i, we_n_i, ucas_n_i, lcas_n_i, ras_n_i};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      prv <= cur;
    end
  end

  assign cur = pipe[SYNC_STAGES-1];

  wire       ras_fall   = prv[0] & ~cur[0];
  wire       ras_rise   = ~prv[0] & cur[0];
  wire [1:0] cas_lo     = ~cur[2:1];
  wire [1:0] cas_fell   = prv[2:1] & ~cur[2:1];
  wire       mode       = |cas_lo;
  wire       mode_prev  = ~&prv[2:1];
  wire       mode_start = mode & ~mode_prev;
  wire       we_lo      = ~cur[3];
  wire       we_fell    = prv[3] & we_lo;
  wire       oe_lo      = ~cur[4];

  logic       open_q, cbr_q, cas_seen_q, early_q, late_q, rmw_q, oe_seen_q, stg_q;
  logic [1:0] lead_q, lanes_q;

  wire track = open_q & ~cbr_q & ~cur[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; cbr_q <= 1'b0; cas_seen_q <= 1'b0; early_q <= 1'b0;
      late_q <= 1'b0; rmw_q <= 1'b0; oe_seen_q <= 1'b0; stg_q <= 1'b0;
      lead_q <= '0;   lanes_q <= '0;
    end else if (ras_fall) begin
      open_q <= 1'b1; cbr_q <= mode; cas_seen_q <= 1'b0; early_q <= 1'b0;
      late_q <= 1'b0; rmw_q <= 1'b0; oe_seen_q <= 1'b0; stg_q <= 1'b0;
      lead_q <= '0;   lanes_q <= '0;
    end else if (ras_rise) begin
      open_q <= 1'b0;
    end else if (track) begin
      if (mode_start) begin
        cas_seen_q <= 1'b1;
        lead_q     <= cas_fell;
        oe_seen_q  <= oe_lo;
        if (we_lo) early_q <= 1'b1;
      end else if (mode) begin
        if (|(cas_fell & ~lead_q)) stg_q <= 1'b1;
        if (oe_lo) oe_seen_q <= 1'b1;
        if (we_fell) begin
          if (oe_seen_q | oe_lo) rmw_q <= 1'b1;
          else                   late_q <= 1'b1;
        end
      end
      lanes_q <= lanes_q | (cas_lo & {2{we_lo}});
    end
  end

  kind_e close_kind;
  always_comb begin
    if      (cbr_q)       close_kind = K_CBR;
    else if (!cas_seen_q) close_kind = K_RONLY;
    else if (early_q)     close_kind = K_EARLY;
    else if (rmw_q)       close_kind = K_RMW;
    else if (late_q)      close_kind = K_LATE;
    else                  close_kind = K_READ;
  end

  wire closing = ras_rise & open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_valid_o <= 1'b0;
      cyc_kind_o  <= K_IDLE;
      wr_lanes_o  <= '0;
      stagger_o   <= 1'b0;
    end else begin
      cyc_valid_o <= closing;
      cyc_kind_o  <= closing ? close_kind : K_IDLE;
      wr_lanes_o  <= closing ? lanes_q : '0;
      stagger_o   <= closing & stg_q & ~cbr_q;
    end
  end
endmodule

module strobe_cycle_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_valid_o,
  input logic [2:0] cyc_kind_o,
  input logic [1:0] wr_lanes_o,
  input logic       stagger_o
);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid_o |=> !cyc_valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid_o |-> (cyc_kind_o == 3'd0 && wr_lanes_o == 2'd0 && !stagger_o));
  assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid_o |-> (cyc_kind_o != 3'd0 && cyc_kind_o != 3'd7));
  assert_refresh_no_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_o && cyc_kind_o == 3'd6) |-> (wr_lanes_o == 2'd0 && !stagger_o));
  assert_ronly_no_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_o && cyc_kind_o == 3'd5) |-> (wr_lanes_o == 2'd0 && !stagger_o));
  assert_read_no_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_o && cyc_kind_o == 3'd1) |-> wr_lanes_o == 2'd0);
  assert_write_has_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid_o && cyc_kind_o >= 3'd2 && cyc_kind_o <= 3'd4) |-> wr_lanes_o != 2'd0);
endmodule

bind strobe_cycle_classifier strobe_cycle_classifier_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid_o(cyc_valid_o),
  .cyc_kind_o(cyc_kind_o), .wr_lanes_o(wr_lanes_o), .stagger_o(stagger_o));

// File: tb/test_strobe_cycle_classifier.sv
module test_strobe_cycle_classifier;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic       valid, stg;
  logic [2:0] kind;
  logic [1:0] lanes;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  strobe_cycle_classifier i_strobe_cycle_classifier (
    .clk(clk), .rst_n(rst_n), .ras_n_i(ras_n), .ucas_n_i(ucas_n), .lcas_n_i(lcas_n),
    .we_n_i(we_n), .oe_n_i(oe_n), .cyc_valid_o(valid), .cyc_kind_o(kind),
    .wr_lanes_o(lanes), .stagger_o(stg));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic r, input logic u, input logic l, input logic w, input logic o);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
    repeat (3) @(negedge clk);
  endtask

  task automatic close_cycle(input string req, input int ek, input int em, input int es);
    int   got_k = 0, got_m = 0, got_s = 0;
    logic seen = 1'b0;
    ras_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!seen && valid) begin
        seen = 1'b1; got_k = kind; got_m = lanes; got_s = stg;
        @(negedge clk);
        chk("R10", "pulse width", valid, 0);
        break;
      end
    end
    chk("R10", "pulse seen", seen, 1);
    chk(req, "code", got_k, ek);
    chk("R7", "lanes", got_m, em);
    chk("R8", "stagger", got_s, es);
    put(1, 1, 1, 1, 1);
  endtask

  task automatic t_reset();
    chk("R10", "reset valid", valid, 0);
    chk("R10", "reset code", kind, 0);
    chk("R10", "reset lanes", lanes, 0);
    chk("R10", "reset stagger", stg, 0);
  endtask

  task automatic t_read();
    put(0, 1, 1, 1, 1);
    put(0, 0, 0, 1, 0);
    put(0, 1, 1, 1, 1);
    close_cycle("R6", 1, 0, 0);
  endtask

  task automatic t_early_word();
    put(1, 1, 1, 0, 1);
    put(0, 1, 1, 0, 1);
    put(0, 0, 0, 0, 1);
    put(0, 1, 1, 1, 1);
    close_cycle("R3", 2, 3, 0);
  endtask

  task automatic t_early_lower();
    put(0, 1, 1, 0, 1);
    put(0, 1, 0, 0, 1);
    put(0, 1, 1, 1, 1);
    close_cycle("R9", 2, 1, 0);
  endtask

  task automatic t_delayed_upper();
    put(0, 1, 1, 1, 1);
    put(0, 0, 1, 1, 1);
    put(0, 0, 1, 0, 1);
    put(0, 1, 1, 1, 1);
    close_cycle("R4", 3, 2, 0);
  endtask

  task automatic t_rmw();
    put(0, 1, 1, 1, 1);
    put(0, 0, 0, 1, 0);
    put(0, 0, 0, 1, 1);
    put(0, 0, 0, 0, 1);
    put(0, 1, 1, 1, 1);
    close_cycle("R5", 4, 3, 0);
  endtask

  task automatic t_ras_only();
    put(0, 1, 1, 1, 1);
    put(0, 1, 1, 0, 1);
    close_cycle("R2", 5, 0, 0);
  endtask

  task automatic t_cbr();
    put(1, 1, 0, 1, 1);
    put(0, 1, 0, 1, 1);
    put(0, 0, 0, 0, 1);
    put(0, 1, 1, 1, 1);
    close_cycle("R1", 6, 0, 0);
  endtask

  task automatic t_cbr_same_sample();
    put(0, 0, 0, 1, 1);
    put(0, 1, 1, 1, 1);
    close_cycle("R1", 6, 0, 0);
  endtask

  task automatic t_stagger();
    put(0, 1, 1, 1, 1);
    put(0, 1, 0, 1, 0);
    put(0, 0, 0, 1, 0);
    put(0, 1, 1, 1, 1);
    close_cycle("R8", 1, 0, 1);
  endtask

  task automatic t_page();
    put(0, 1, 1, 1, 1);
    put(0, 0, 0, 1, 0);
    put(0, 1, 1, 1, 1);
    put(0, 1, 1, 0, 1);
    put(0, 0, 0, 0, 1);
    put(0, 1, 1, 1, 1);
    close_cycle("R9", 2, 3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read();
    t_early_word();
    t_early_lower();
    t_delayed_upper();
    t_rmw();
    t_ras_only();
    t_cbr();
    t_cbr_same_sample();
    t_stagger();
    t_page();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule